// File: doc/BRIEF.md
# Configuration Access Filter and Router

This block sits in front of a root port's configuration access machinery. Every configuration read or write, given as a bus, device, function, register offset, access size and write data, is classified in a single cycle. The block decides whether the access is dropped silently, answered on the spot with all-ones data, steered to the root port's own memory-mapped configuration window, or handed to the packet path that builds link transactions. The packet path itself lies outside this block; it receives the dword-aligned offset from here.

The block keeps its own copy of the root bus number. An access whose bus matches that copy targets the root port. A successful root-port write to the primary bus number register replaces the copy. The root port's first base address register is kept out of sight of enumeration software. Downstream accesses are refused while the link is down. Only device 0 is reachable on the root bus and on the bus directly below it.

Top module: `cfg_access_router`

## Requirements
- R1: An access is a root-port access exactly when `req_bus` equals the stored root bus number. A valid root-port access is routed to the direct window even when `link_active` is low.
- R2: A root-port access to device 0, function 0 at offset exactly 0x010 is hidden. A read gets route 2'b01 (all ones) and a write gets route 2'b00 (drop). Any other function or offset, 0x011 included, is not hidden.
- R3: A non-root access while `link_active` is low is invalid: a read gets route 2'b01 and a write gets route 2'b00. Route 2'b11 (packet) is never given while the link is down.
- R4: A root-port access with a nonzero device is invalid, and so is an access to bus root+1 with a nonzero device; both take the R3 outcome. Root+1 is an unwrapped 9-bit sum, so with root 0xFF no bus counts as the first downstream bus.
- R5: A valid root-port access gets route 2'b10 (direct) with `rsp_addr` = `cfg_base` + 0x100000 + `req_off`, keeping the unaligned offset and taken modulo 2^ADDR_W.
- R6: A write that takes route 2'b10 at offset exactly 0x018, of any size, loads `req_wdata[7:0]` into the stored root bus number. A request accepted in the following cycle already sees the new value. Dropped writes to 0x018 leave the number unchanged.
- R7: Every other valid access gets route 2'b11 with `rsp_pkt_off` equal to `req_off` with bits [1:0] cleared.
- R8: All-ones data has the width of the access: `req_size` 0 gives 0x000000FF, 1 gives 0x0000FFFF, and 2 or 3 give 0xFFFFFFFF. `rsp_rdata` is 0 for every other route. `rsp_addr` is 0 unless the route is direct, and `rsp_pkt_off` is 0 unless the route is packet.
- R9: Reset loads the stored root bus number from parameter ROOT_RESET (default 0) and clears `rsp_valid`.
- R10: The decision for a request sampled with `req_valid` high is presented, with `rsp_valid` high, on the next cycle. In a cycle without a response, `rsp_route` is 2'b00 and all data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_off | input | 12 | Register byte offset |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_wdata | input | 32 | Write data (low byte used for the root bus snoop) |
| link_active | input | 1 | Data-link-layer link-active status |
| cfg_base | input | ADDR_W | Base address of the root port configuration region |
| rsp_valid | output | 1 | Decision valid |
| rsp_route | output | 2 | 00 drop, 01 all ones, 10 direct, 11 packet |
| rsp_addr | output | ADDR_W | Direct-window address |
| rsp_pkt_off | output | 12 | Dword-aligned offset for the packet path |
| rsp_rdata | output | 32 | Synthesized all-ones read data |

## Verification
The bound checker watches on every cycle the response timing, the quiet outputs between responses, and the direct address arithmetic. It also checks that packet offsets are aligned, that no packet is issued while the link is down, that all-ones answers go only to reads and drops only to writes, and that byte reads get 0xFF. The classification itself depends on the stored root bus number, so only the bench's scenarios can show it. These cover BAR0 hiding against its near misses, the one-slot rule on the root and first downstream buses, and the snoop of the primary bus write taking effect on the next back-to-back request. They also cover writes that are dropped leaving the number alone, and the root bus at 0xFF where root+1 must not wrap.

// File: rtl/cfgf_pkg.sv
package cfgf_pkg;

    typedef enum logic [1:0] {
        RT_DROP   = 2'b00,
        RT_ONES   = 2'b01,
        RT_DIRECT = 2'b10,
        RT_PACKET = 2'b11
    } route_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/cfgf_classify.sv
module cfgf_classify #(
    parameter int unsigned BUS_W    = 8,
    parameter int unsigned DEV_W    = 5,
    parameter int unsigned FN_W     = 3,
    parameter int unsigned OFF_W    = 12,
    parameter int unsigned HIDE_OFS = 'h010
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [FN_W-1:0]  fn,
    input  logic [OFF_W-1:0] off,
    input  logic [BUS_W-1:0] root_bus,
    input  logic             link_active,
    output logic             is_root,
    output logic             is_hidden,
    output logic             is_invalid
);
    localparam logic [OFF_W-1:0] HIDE_AT = OFF_W'(HIDE_OFS);

    logic [BUS_W:0] below_root;
    logic           on_first_down;
    logic           dev_nonzero;

    always_comb begin
        below_root    = {1'b0, root_bus} + {{BUS_W{1'b0}}, 1'b1};
        on_first_down = ({1'b0, bus} == below_root);
        dev_nonzero   = |dev;
        is_root       = (bus == root_bus);
        is_hidden     = is_root && !dev_nonzero && (fn == '0) && (off == HIDE_AT);
        is_invalid    = (!is_root && !link_active)
                     || (is_root && dev_nonzero)
                     || (on_first_down && dev_nonzero);
    end
endmodule

// File: rtl/cfgf_ones_fill.sv
module cfgf_ones_fill #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] ones
);
    localparam int unsigned LANES = DATA_W / 8;

    logic [3:0] nbytes;

    always_comb begin
        case (size)
            cfgf_pkg::SZ_BYTE: nbytes = 4'd1;
            cfgf_pkg::SZ_HALF: nbytes = 4'd2;
            default:           nbytes = 4'(LANES);
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign ones[i*8 +: 8] = (4'(i) < nbytes) ? 8'hFF : 8'h00;
    end
endmodule

// File: rtl/cfgf_root_track.sv
module cfgf_root_track #(
    parameter int unsigned BUS_W      = 8,
    parameter int unsigned ROOT_RESET = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [BUS_W-1:0] upd_val,
    output logic [BUS_W-1:0] root_bus
);
    logic [BUS_W-1:0] root_d, root_q;

    always_comb begin
        root_d = root_q;
        if (upd) root_d = upd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) root_q <= BUS_W'(ROOT_RESET);
        else        root_q <= root_d;
    end

    assign root_bus = root_q;
endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router #(
    parameter int unsigned BUS_W      = 8,
    parameter int unsigned DEV_W      = 5,
    parameter int unsigned FN_W       = 3,
    parameter int unsigned OFF_W      = 12,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] WINDOW_OFS = 'h0010_0000,
    parameter int unsigned HIDE_OFS   = 'h010,
    parameter int unsigned PRIBUS_OFS = 'h018,
    parameter int unsigned ROOT_RESET = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FN_W-1:0]   req_fn,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              link_active,
    input  logic [ADDR_W-1:0] cfg_base,
    output logic              rsp_valid,
    output logic [1:0]        rsp_route,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [OFF_W-1:0]  rsp_pkt_off,
    output logic [DATA_W-1:0] rsp_rdata
);
    import cfgf_pkg::*;

    localparam logic [OFF_W-1:0] PRIBUS_AT = OFF_W'(PRIBUS_OFS);

    typedef struct packed {
        logic              valid;
        route_e            route;
        logic [ADDR_W-1:0] addr;
        logic [OFF_W-1:0]  pkt_off;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic             is_root, is_hidden, is_invalid;
    logic [BUS_W-1:0] root_bus;
    logic [DATA_W-1:0] ones;
    logic             snoop_upd;
    route_e           route_c;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^req_wdata[DATA_W-1:BUS_W];

    cfgf_classify #(
        .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W),
        .OFF_W(OFF_W), .HIDE_OFS(HIDE_OFS)
    ) u_classify (
        .bus(req_bus), .dev(req_dev), .fn(req_fn), .off(req_off),
        .root_bus(root_bus), .link_active(link_active),
        .is_root(is_root), .is_hidden(is_hidden), .is_invalid(is_invalid)
    );

    cfgf_ones_fill #(.DATA_W(DATA_W)) u_fill (
        .size(req_size), .ones(ones)
    );

    cfgf_root_track #(.BUS_W(BUS_W), .ROOT_RESET(ROOT_RESET)) u_root (
        .clk(clk), .rst_n(rst_n), .upd(snoop_upd),
        .upd_val(req_wdata[BUS_W-1:0]), .root_bus(root_bus)
    );

    always_comb begin
        if (is_hidden || is_invalid) route_c = req_write ? RT_DROP : RT_ONES;
        else if (is_root)            route_c = RT_DIRECT;
        else                         route_c = RT_PACKET;

        snoop_upd = req_valid && req_write && (route_c == RT_DIRECT)
                 && (req_off == PRIBUS_AT);

        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.route = route_c;
            case (route_c)
                RT_ONES:   rsp_d.rdata   = ones;
                RT_DIRECT: rsp_d.addr    = cfg_base + WINDOW_OFS + ADDR_W'(req_off);
                RT_PACKET: rsp_d.pkt_off = {req_off[OFF_W-1:2], 2'b00};
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_route   = rsp_q.route;
    assign rsp_addr    = rsp_q.addr;
    assign rsp_pkt_off = rsp_q.pkt_off;
    assign rsp_rdata   = rsp_q.rdata;
endmodule

// File: rtl/cfgf_checker.sv
module cfgf_checker #(
    parameter int unsigned OFF_W  = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32,
    parameter logic [ADDR_W-1:0] WINDOW_OFS = 'h0010_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [OFF_W-1:0]  req_off,
    input logic [1:0]        req_size,
    input logic              link_active,
    input logic [ADDR_W-1:0] cfg_base,
    input logic              rsp_valid,
    input logic [1:0]        rsp_route,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic [OFF_W-1:0]  rsp_pkt_off,
    input logic [DATA_W-1:0] rsp_rdata
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_rsp_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (rsp_valid == $past(req_valid)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_route == 2'b00 && rsp_rdata == '0 && rsp_addr == '0));

    p_direct_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_route == 2'b10) |->
        (rsp_addr == $past(cfg_base) + WINDOW_OFS + ADDR_W'($past(req_off))));

    p_pkt_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_route == 2'b11) |->
        (rsp_pkt_off[1:0] == 2'b00 && rsp_pkt_off[OFF_W-1:2] == $past(req_off[OFF_W-1:2])));

    p_pkt_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_route == 2'b11) |-> $past(link_active));

    p_ones_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_route == 2'b01) |-> !$past(req_write));

    p_drop_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_route == 2'b00) |-> $past(req_write));

    p_byte_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_route == 2'b01 && $past(req_size) == 2'd0) |->
        (rsp_rdata == DATA_W'(8'hFF)));
endmodule

bind cfg_access_router cfgf_checker #(
    .OFF_W(OFF_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WINDOW_OFS(WINDOW_OFS)
) u_cfgf_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_off(req_off), .req_size(req_size), .link_active(link_active),
    .cfg_base(cfg_base), .rsp_valid(rsp_valid), .rsp_route(rsp_route),
    .rsp_addr(rsp_addr), .rsp_pkt_off(rsp_pkt_off), .rsp_rdata(rsp_rdata)
);

// File: tb/test_cfg_access_router.sv
`timescale 1ns/1ps
module test_cfg_access_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_fn = '0;
    logic [11:0] req_off = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        link_active = 1'b1;
    logic [31:0] cfg_base = 32'h4000_0000;
    logic        rsp_valid;
    logic [1:0]  rsp_route;
    logic [31:0] rsp_addr;
    logic [11:0] rsp_pkt_off;
    logic [31:0] rsp_rdata;

    int tests = 0, fails = 0;
    logic [7:0] root_m = 8'h00;
    bit done = 0;

    always #2.5 clk = ~clk;

    cfg_access_router i_cfg_access_router (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn), .req_off(req_off),
        .req_size(req_size), .req_wdata(req_wdata), .link_active(link_active),
        .cfg_base(cfg_base), .rsp_valid(rsp_valid), .rsp_route(rsp_route),
        .rsp_addr(rsp_addr), .rsp_pkt_off(rsp_pkt_off), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_route(input logic wr, input logic [7:0] bus,
            input logic [4:0] dev, input logic [2:0] fn, input logic [11:0] off,
            input logic link, input logic [7:0] root);
        logic is_root, hid, inv, down;
        is_root = (bus == root);
        down    = ({1'b0, bus} == ({1'b0, root} + 9'd1));
        hid     = is_root && dev == 0 && fn == 0 && off == 12'h010;
        inv     = (!is_root && !link) || (is_root && dev != 0) || (down && dev != 0);
        if (hid || inv) return wr ? 2'b00 : 2'b01;
        if (is_root) return 2'b10;
        return 2'b11;
    endfunction

    function automatic logic [31:0] exp_ones(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    // Called at a negative edge; leaves req_valid high for back-to-back use.
    task automatic send(input logic wr, input logic [7:0] bus, input logic [4:0] dev,
                        input logic [2:0] fn, input logic [11:0] off, input logic [1:0] sz,
                        input logic [31:0] wd, input logic link, input string tag);
        logic [1:0]  er;
        logic [31:0] ea, ed;
        logic [11:0] ep;
        er = exp_route(wr, bus, dev, fn, off, link, root_m);
        ea = (er == 2'b10) ? cfg_base + 32'h0010_0000 + {20'd0, off} : 32'd0;
        ep = (er == 2'b11) ? {off[11:2], 2'b00} : 12'd0;
        ed = (er == 2'b01) ? exp_ones(sz) : 32'd0;
        req_valid = 1'b1; req_write = wr; req_bus = bus; req_dev = dev; req_fn = fn;
        req_off = off; req_size = sz; req_wdata = wd; link_active = link;
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid === 1'b1, tag, "valid", {31'd0, rsp_valid}, 32'd1);
        chk(rsp_route === er, tag, "route", {30'd0, rsp_route}, {30'd0, er});
        chk(rsp_addr === ea, tag, "addr", rsp_addr, ea);
        chk(rsp_pkt_off === ep, tag, "pkt_off", {20'd0, rsp_pkt_off}, {20'd0, ep});
        chk(rsp_rdata === ed, tag, "rdata", rsp_rdata, ed);
        if (wr && er == 2'b10 && off == 12'h018) root_m = wd[7:0];
    endtask

    task automatic idle(input string tag);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid === 1'b0 && rsp_route === 2'b00 && rsp_rdata === 32'd0,
            tag, "idle", {rsp_valid, 29'd0, rsp_route}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(rsp_valid === 1'b0, "R9", "reset valid", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 / R1: reset root bus 0 is the root port, direct window
        send(0, 8'h00, 0, 0, 12'h000, 2, 0, 1, "R9");
        idle("R10");
        send(0, 8'h00, 0, 0, 12'h0A6, 0, 0, 1, "R5");
        // R2 hide and its near misses
        send(0, 8'h00, 0, 0, 12'h010, 2, 0, 1, "R2");
        send(1, 8'h00, 0, 0, 12'h010, 2, 32'h1234, 1, "R2");
        send(0, 8'h00, 0, 1, 12'h010, 2, 0, 1, "R2");
        send(0, 8'h00, 0, 0, 12'h011, 0, 0, 1, "R2");
        // R4 one slot on root and first downstream bus
        send(0, 8'h00, 3, 0, 12'h000, 2, 0, 1, "R4");
        send(1, 8'h01, 1, 0, 12'h004, 2, 0, 1, "R4");
        send(0, 8'h02, 4, 0, 12'h0A7, 2, 0, 1, "R7");
        send(0, 8'h01, 0, 0, 12'h0A7, 1, 0, 1, "R7");
        // R3 link down, R8 widths, R1 root still direct
        send(0, 8'h01, 0, 0, 12'h000, 1, 0, 0, "R3");
        send(1, 8'h05, 0, 0, 12'h000, 2, 0, 0, "R3");
        send(0, 8'h00, 0, 2, 12'h040, 2, 0, 0, "R1");
        send(0, 8'h00, 2, 0, 12'h003, 0, 0, 1, "R8");
        send(0, 8'h07, 0, 0, 12'h003, 3, 0, 0, "R8");
        // R6 snoop: dropped write leaves root alone, then a real update
        send(1, 8'h00, 1, 0, 12'h018, 2, 32'h07, 1, "R6");
        send(0, 8'h00, 0, 0, 12'h000, 2, 0, 1, "R6");
        send(1, 8'h00, 0, 0, 12'h018, 0, 32'hABCD_EF05, 1, "R6");
        send(0, 8'h05, 0, 0, 12'h000, 2, 0, 0, "R6");
        send(0, 8'h00, 0, 0, 12'h000, 2, 0, 1, "R6");
        send(0, 8'h06, 1, 0, 12'h000, 2, 0, 1, "R4");
        // R4 no wrap of root+1 at 0xFF
        send(1, 8'h05, 0, 0, 12'h018, 2, 32'hFF, 1, "R6");
        send(0, 8'h00, 1, 0, 12'h00C, 2, 0, 1, "R4");
        send(1, 8'hFF, 0, 0, 12'h018, 2, 32'h00, 1, "R6");
        idle("R10");
        // Constrained random traffic
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 600; i++) begin
            logic [7:0]  b;
            logic [11:0] o;
            logic [4:0]  d;
            if (i % 50 == 0) cfg_base = $urandom & 32'hFFFF_F000;
            b = ($urandom % 4 == 0) ? 8'($urandom) : root_m + 8'($urandom % 3);
            d = ($urandom % 2 == 0) ? 5'd0 : 5'($urandom);
            case ($urandom % 4)
                0: o = 12'h010;
                1: o = 12'h018;
                default: o = 12'($urandom);
            endcase
            send(1'($urandom), b, d, 3'($urandom % 2), o, 2'($urandom),
                 $urandom, ($urandom % 5) != 0, "R7");
            if ($urandom % 8 == 0) idle("R10");
        end
        idle("R10");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                tests++; fails++;
                $display("FAIL watchdog: actual running expected done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule